// File: doc/BRIEF.md
# Linked Frame Descriptor Streamer

This engine feeds a display or video pipeline from memory without processor help. Each frame is described by a record of four 32-bit words in memory: the address of the following record, the start address of the pixel buffer, a frame identifier and a command word. Software writes the address of the first record to an input and raises `enable`. The engine then reads the record, fetches the buffer in fixed-size bursts and delivers the buffer as a stream of 32-bit words with valid/ready flow control. After that it moves on to the record that the link word names. A record that links to itself shows the same buffer on every frame with no further software action.

The command word holds two things. The low 24 bits give the buffer length in words, which is width × height × bytes-per-pixel / 4. Bits 31 and 30 request a start-of-frame and an end-of-frame notification. The engine issues a one-cycle `frame_done` pulse that carries both flags when the last word of a frame leaves the output. Records with zero length are passed over. The identifier, the command and the running source address of the current record are visible on read-only outputs.

Top module: `desc_chain_fetch`

## Requirements
- R1: When `enable` is high while the engine is idle, it issues one read of 4 words at `desc_ptr_init`. The returned words are used in this order: link address, buffer address, frame id, command.
- R2: A frame delivers exactly cmd[23:0] words on `out_data`. They come from byte addresses buf, buf+4, buf+8 and so on, in ascending order.
- R3: Buffer reads are requests of B words, where B is 4, 8, 16 or 16 for `burst_sel` = 0, 1, 2 or 3. The final request of a frame carries the remainder. Only one request is outstanding at a time, and `mem_req` is a one-cycle pulse.
- R4: After the last word of a frame has been accepted, the next request is the 4-word read of the record at that frame's link address. A record that links to itself repeats its buffer.
- R5: `frame_done` is high for exactly the one cycle after the clock edge that accepts a frame's final word. At that time `frame_sof` equals cmd[31] and `frame_eof` equals cmd[30].
- R6: A record with cmd[23:0] = 0 produces no output words, no buffer reads and no `frame_done`. The engine goes straight on to read the record at its link address.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. A buffer read is issued only when the output FIFO has room for every word of that read, so no word is lost.
- R8: During `frame_done`, `cur_frame_id` and `cur_cmd` equal the frame's record words, and `cur_src_addr` equals buf + 4 × length.
- R9: If `enable` is low when a frame's final word is accepted, the engine goes idle and issues no further requests. On the next `enable` it restarts from `desc_ptr_init`.
- R10: During and after a synchronous reset, `mem_req`, `out_valid` and `frame_done` are low and the read-only registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the chain; sampled when idle and at each frame end |
| desc_ptr_init | input | 32 | Byte address of the first record |
| burst_sel | input | 2 | Buffer burst size select (4/8/16/16 words) |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Byte address of the request |
| mem_words | output | 5 | Word count of the request |
| mem_rvalid | input | 1 | Read data word valid |
| mem_rdata | input | 32 | Read data word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output consumer ready |
| out_data | output | 32 | Output word |
| frame_done | output | 1 | Frame completion pulse |
| frame_sof | output | 1 | Start-of-frame request flag of the completed frame |
| frame_eof | output | 1 | End-of-frame request flag of the completed frame |
| cur_src_addr | output | 32 | Next buffer address to be requested |
| cur_frame_id | output | 32 | Frame id of the current record |
| cur_cmd | output | 32 | Command word of the current record |

## Verification
`mem_req` is registered. It appears in the cycle after the state that decides on it, and the bench's memory answers no earlier than the cycle after it sees the request. An output word counts as taken on the edge where `out_valid` and `out_ready` are both high. `frame_done` and its flags must then be visible in the very next cycle. The bench samples everything at the falling edge. At that point it predicts the handshake for the coming rising edge, and one falling edge later it requires the completion pulse exactly, never earlier and never later. Read requests are compared in order against a queue that the bench derives by walking the record chain in its own memory image. Output words are compared against a second queue derived in the same way.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int LEN_W      = 24;
    localparam int DESC_WORDS = 4;
    localparam int SOF_BIT    = 31;
    localparam int EOF_BIT    = 30;
    localparam int MAX_BURST  = 16;
    localparam int BURST_W    = $clog2(MAX_BURST + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DREQ,
        ST_DRECV,
        ST_STREAM
    } seq_state_t;

    typedef struct packed {
        logic              last;
        logic [DATA_W-1:0] data;
    } beat_t;

    function automatic logic [BURST_W-1:0] burst_words(input logic [1:0] sel);
        case (sel)
            2'd0:    return BURST_W'(4);
            2'd1:    return BURST_W'(8);
            default: return BURST_W'(16);
        endcase
    endfunction
endpackage

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
    parameter  int DEPTH = 16,
    parameter  int WIDTH = 33,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic             wr_ok, rd_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign wr_ok   = wr_en && !full;
    assign rd_ok   = rd_en && !empty;
    assign rd_data = store[rp];

    always_ff @(posedge clk) begin
        if (wr_ok) store[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wp <= wp + AW'(1);
            if (rd_ok) rp <= rp + AW'(1);
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/dcf_seq.sv
module dcf_seq
    import dcf_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [ADDR_W-1:0]  desc_ptr_init,
    input  logic [1:0]         burst_sel,
    input  logic               mem_rvalid,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic [CNT_W-1:0]   fifo_count,
    input  logic               out_fire,
    input  logic               out_last,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [BURST_W-1:0] mem_words,
    output logic               fifo_wr_en,
    output logic               fifo_wr_last,
    output logic               frame_done,
    output logic               frame_sof,
    output logic               frame_eof,
    output logic [ADDR_W-1:0]  cur_src,
    output logic [DATA_W-1:0]  cur_id,
    output logic [DATA_W-1:0]  cur_cmd
);
    localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(FIFO_DEPTH);

    seq_state_t         state;
    logic [ADDR_W-1:0]  dptr, link_ptr;
    logic [LEN_W-1:0]   remain, burst_len, chunk;
    logic [BURST_W-1:0] inflight;
    logic [1:0]         rx_idx;
    logic               room, can_issue, rx_word;
    logic [LEN_W-1:0]   new_len;

    assign burst_len = LEN_W'(burst_words(burst_sel));
    assign chunk     = (remain < burst_len) ? remain : burst_len;
    assign room      = (LEN_W'(fifo_count) + chunk) <= DEPTH_L;
    assign can_issue = (state == ST_STREAM) && (inflight == '0) && (remain != '0) && room;
    assign rx_word   = mem_rvalid && (state == ST_STREAM);
    assign new_len   = mem_rdata[LEN_W-1:0];

    assign fifo_wr_en   = rx_word;
    assign fifo_wr_last = rx_word && (remain == '0) && (inflight == BURST_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            dptr       <= '0;
            link_ptr   <= '0;
            remain     <= '0;
            inflight   <= '0;
            rx_idx     <= '0;
            mem_req    <= 1'b0;
            mem_addr   <= '0;
            mem_words  <= '0;
            frame_done <= 1'b0;
            frame_sof  <= 1'b0;
            frame_eof  <= 1'b0;
            cur_src    <= '0;
            cur_id     <= '0;
            cur_cmd    <= '0;
        end else begin
            mem_req    <= 1'b0;
            frame_done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (enable) begin
                        dptr  <= desc_ptr_init;
                        state <= ST_DREQ;
                    end
                end
                ST_DREQ: begin
                    mem_req   <= 1'b1;
                    mem_addr  <= dptr;
                    mem_words <= BURST_W'(DESC_WORDS);
                    rx_idx    <= '0;
                    state     <= ST_DRECV;
                end
                ST_DRECV: begin
                    if (mem_rvalid) begin
                        rx_idx <= rx_idx + 2'd1;
                        case (rx_idx)
                            2'd0: link_ptr <= mem_rdata;
                            2'd1: cur_src  <= mem_rdata;
                            2'd2: cur_id   <= mem_rdata;
                            default: begin
                                cur_cmd <= mem_rdata;
                                remain  <= new_len;
                                if (new_len == '0) begin
                                    dptr  <= link_ptr;
                                    state <= enable ? ST_DREQ : ST_IDLE;
                                end else begin
                                    state <= ST_STREAM;
                                end
                            end
                        endcase
                    end
                end
                ST_STREAM: begin
                    if (can_issue) begin
                        mem_req   <= 1'b1;
                        mem_addr  <= cur_src;
                        mem_words <= chunk[BURST_W-1:0];
                        cur_src   <= cur_src + (ADDR_W'(chunk) << 2);
                        remain    <= remain - chunk;
                        inflight  <= chunk[BURST_W-1:0];
                    end else if (rx_word) begin
                        inflight <= inflight - BURST_W'(1);
                    end
                    if (out_fire && out_last) begin
                        frame_done <= 1'b1;
                        frame_sof  <= cur_cmd[SOF_BIT];
                        frame_eof  <= cur_cmd[EOF_BIT];
                        dptr       <= link_ptr;
                        state      <= enable ? ST_DREQ : ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/desc_chain_fetch.sv
module desc_chain_fetch
    import dcf_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [31:0]        desc_ptr_init,
    input  logic [1:0]         burst_sel,
    output logic               mem_req,
    output logic [31:0]        mem_addr,
    output logic [4:0]         mem_words,
    input  logic               mem_rvalid,
    input  logic [31:0]        mem_rdata,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [31:0]        out_data,
    output logic               frame_done,
    output logic               frame_sof,
    output logic               frame_eof,
    output logic [31:0]        cur_src_addr,
    output logic [31:0]        cur_frame_id,
    output logic [31:0]        cur_cmd
);
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
    localparam int BEAT_W = $bits(beat_t);

    logic             fifo_wr_en, fifo_wr_last, fifo_empty, fifo_full;
    logic [CNT_W-1:0] fifo_count;
    beat_t            wr_beat, head;
    logic             out_fire;

    assign wr_beat   = '{last: fifo_wr_last, data: mem_rdata};
    assign out_valid = !fifo_empty;
    assign out_data  = head.data;
    assign out_fire  = out_valid && out_ready;

    dcf_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BEAT_W)) fifo_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (fifo_wr_en),
        .wr_data (wr_beat),
        .rd_en   (out_fire),
        .rd_data (head),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .count   (fifo_count)
    );

    dcf_seq #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) seq_i (
        .clk           (clk),
        .rst           (rst),
        .enable        (enable),
        .desc_ptr_init (desc_ptr_init),
        .burst_sel     (burst_sel),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .fifo_count    (fifo_count),
        .out_fire      (out_fire),
        .out_last      (head.last),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .mem_words     (mem_words),
        .fifo_wr_en    (fifo_wr_en),
        .fifo_wr_last  (fifo_wr_last),
        .frame_done    (frame_done),
        .frame_sof     (frame_sof),
        .frame_eof     (frame_eof),
        .cur_src       (cur_src_addr),
        .cur_id        (cur_frame_id),
        .cur_cmd       (cur_cmd)
    );
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_req,
    input logic [4:0]  mem_words,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        frame_done,
    input logic        fifo_wr_en,
    input logic        fifo_full
);
    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_wr_en |-> !fifo_full);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R3
    burst_size_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_words != 5'd0 && mem_words <= 5'd16));

    // R3
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);
endmodule

bind desc_chain_fetch dcf_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .mem_req    (mem_req),
    .mem_words  (mem_words),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .frame_done (frame_done),
    .fifo_wr_en (fifo_wr_en),
    .fifo_full  (fifo_full)
);

// File: tb/desc_chain_fetch_tb_top.sv
module desc_chain_fetch_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [31:0] desc_ptr_init = '0;
    logic [1:0]  burst_sel = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [4:0]  mem_words;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        frame_done, frame_sof, frame_eof;
    logic [31:0] cur_src_addr, cur_frame_id, cur_cmd;

    always #10 clk = ~clk;

    desc_chain_fetch dut_i (.*);

    typedef struct {
        logic [31:0] a;
        int          n;
        string       tag;
    } req_t;

    typedef struct {
        logic [31:0] data;
        bit          last;
        bit          sof;
        bit          eof;
        logic [31:0] id;
        logic [31:0] cmd;
        logic [31:0] end_addr;
    } word_t;

    logic [31:0] mem_w [0:255];
    int          rd_q[$];
    req_t        exp_req[$];
    word_t       exp_out[$];

    int total = 0, bad = 0, cyc = 0, done_cnt = 0, ready_mode = 2;
    bit          fire_last_pend = 0;
    word_t       last_word;
    bit          stall_prev = 0;
    logic [31:0] stall_data;
    bit          live = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic build_model(input logic [31:0] base, input int sel, input int nframes);
        logic [31:0] p, nx, bf, id, cmd, a;
        int produced, len, rem, b, c;
        b = (sel == 0) ? 4 : (sel == 1) ? 8 : 16;
        p = base;
        produced = 0;
        while (produced < nframes) begin
            exp_req.push_back('{p, 4, "R1/R4 record read"});
            nx  = mem_w[p[9:2]];
            bf  = mem_w[p[9:2] + 1];
            id  = mem_w[p[9:2] + 2];
            cmd = mem_w[p[9:2] + 3];
            len = int'(cmd[23:0]);
            if (len != 0) begin
                rem = len;
                a = bf;
                while (rem > 0) begin
                    c = (rem < b) ? rem : b;
                    exp_req.push_back('{a, c, "R3 burst read"});
                    a += 32'(4 * c);
                    rem -= c;
                end
                for (int k = 0; k < len; k++) begin
                    exp_out.push_back('{mem_w[bf[9:2] + k], k == len - 1, cmd[31], cmd[30],
                                        id, cmd, bf + 32'(4 * len)});
                end
                produced++;
            end
            p = nx;
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (live) begin
            // memory model: serve pending words, then accept new request
            mem_rvalid = 1'b0;
            mem_rdata  = '0;
            if (rd_q.size() > 0 && (cyc % 5) != 3) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem_w[rd_q.pop_front()];
            end
            if (mem_req) begin
                if (exp_req.size() == 0) begin
                    chk(0, "R9 unexpected request", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    req_t e;
                    e = exp_req.pop_front();
                    chk(mem_addr == e.a, e.tag, mem_addr, e.a);
                    chk(int'(mem_words) == e.n, "R3 request length", 32'(mem_words), 32'(e.n));
                end
                for (int k = 0; k < int'(mem_words); k++) rd_q.push_back(int'(mem_addr[9:2]) + k);
            end
            // completion pulse due one cycle after the last-word handshake
            if (frame_done || fire_last_pend) begin
                chk(frame_done == fire_last_pend, "R5 frame_done timing", 32'(frame_done), 32'(fire_last_pend));
                if (frame_done && fire_last_pend) begin
                    done_cnt++;
                    chk(frame_sof == last_word.sof, "R5 sof flag", 32'(frame_sof), 32'(last_word.sof));
                    chk(frame_eof == last_word.eof, "R5 eof flag", 32'(frame_eof), 32'(last_word.eof));
                    chk(cur_frame_id == last_word.id, "R8 frame id", cur_frame_id, last_word.id);
                    chk(cur_cmd == last_word.cmd, "R8 command", cur_cmd, last_word.cmd);
                    chk(cur_src_addr == last_word.end_addr, "R8 source address", cur_src_addr, last_word.end_addr);
                end
            end
            // stall hold
            if (stall_prev) begin
                chk(out_valid && out_data == stall_data, "R7 stall hold", out_data, stall_data);
            end
            case (ready_mode)
                0:       out_ready = (cyc % 7) != 0;
                1:       out_ready = (cyc % 4) == 0;
                default: out_ready = 1'b1;
            endcase
            fire_last_pend = 0;
            stall_prev = out_valid && !out_ready;
            stall_data = out_data;
            if (out_valid && out_ready) begin
                if (exp_out.size() == 0) begin
                    chk(0, "R2 unexpected word", out_data, 32'hFFFF_FFFF);
                end else begin
                    word_t w;
                    w = exp_out.pop_front();
                    chk(out_data == w.data, "R2 output word", out_data, w.data);
                    fire_last_pend = w.last;
                    last_word = w;
                end
            end
        end
        if (cyc > 60000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<60000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_test(input logic [31:0] base, input int sel, input int nframes, input int mode);
        done_cnt = 0;
        ready_mode = mode;
        build_model(base, sel, nframes);
        @(negedge clk);
        desc_ptr_init = base;
        burst_sel = 2'(sel);
        enable = 1'b1;
        if (nframes == 1) begin
            repeat (3) @(negedge clk);
        end else begin
            while (done_cnt < nframes - 1) @(negedge clk);
        end
        enable = 1'b0;
        while (exp_out.size() > 0 || exp_req.size() > 0) @(negedge clk);
        repeat (40) @(negedge clk);
        // R9 idle after stop
        chk(!out_valid, "R9 idle output", 32'(out_valid), 0);
        chk(done_cnt == nframes, "R9 frame count", 32'(done_cnt), 32'(nframes));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_w[i] = 32'hC0DE_0000 | 32'(i);
        // chain A: 0x00 -> 0x20 (zero length, R6) -> 0x40 (self link, R4)
        mem_w[0]  = 32'h20;  mem_w[1]  = 32'h100; mem_w[2]  = 32'h11; mem_w[3]  = 32'h4000_000A;
        mem_w[8]  = 32'h40;  mem_w[9]  = 32'h200; mem_w[10] = 32'h22; mem_w[11] = 32'hC000_0000;
        mem_w[16] = 32'h40;  mem_w[17] = 32'h180; mem_w[18] = 32'h33; mem_w[19] = 32'hC000_0005;
        // chain B: self link, 20 words, sof only
        mem_w[24] = 32'h60;  mem_w[25] = 32'h300; mem_w[26] = 32'h44; mem_w[27] = 32'h8000_0014;
        // chain C: single 8-word frame
        mem_w[32] = 32'h00;  mem_w[33] = 32'h140; mem_w[34] = 32'h55; mem_w[35] = 32'h4000_0008;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(!mem_req && !out_valid && !frame_done, "R10 reset outputs", {29'd0, mem_req, out_valid, frame_done}, 0);
        chk(cur_cmd == 0 && cur_frame_id == 0 && cur_src_addr == 0, "R10 reset registers", cur_cmd, 0);
        live = 1;

        run_test(32'h00, 0, 4, 0);   // R1 R2 R3 R4 R6 with light backpressure
        run_test(32'h60, 2, 2, 1);   // R7 heavy backpressure, 16-word bursts
        run_test(32'h80, 1, 1, 2);   // R9 restart from new pointer, 8-word bursts

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule